// File: doc/BRIEF.md
# DMA Completion Interrupt Arbiter

This block takes a one-cycle terminal-count pulse from each of four DMA channels. It keeps a sticky completion flag for every channel and combines the flags with per-channel enable bits and 3-bit priority levels. From this it forms a single prioritized interrupt request toward a CPU. Among the channels whose flag and enable are both set, the one with the highest level wins. The winner's level is then compared with the CPU's present interrupt level and global enable, and the request is raised only when the winner's level is strictly above the CPU's level.

Software reaches the state through a byte-wide register port with four addresses. The flags are cleared by writing ones. Channels 0 and 1 can also forward their completion event as a one-cycle trigger to a secondary DMA engine, and this trigger does not depend on the interrupt enable.

Top module: `dma_irq_arbiter`

## Requirements
- R1: After reset every flag, enable, trigger enable and level reads 0, and irq_req_o is 0.
- R2: A pulse on tc_i[c] sets flag c at that clock edge, whether or not channel c is enabled. The flags read back at address 0 in bits [3:0], with bits [7:4] reading 0.
- R3: Writing address 0 clears each flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: When tc_i[c] and a write of 1 to flag c fall in the same cycle, flag c ends up set.
- R5: Address 1 holds the interrupt enables in bits [3:0] and the trigger enables of channels 0 and 1 in bits [5:4]. Bits [7:6] read 0.
- R6: Address 2 holds the level of channel 0 in bits [2:0] and of channel 1 in bits [6:4]. Address 3 holds channels 2 and 3 in the same positions. Bits 3 and 7 read 0.
- R7: A channel is a candidate when its flag and its enable are both 1. irq_ch_o and irq_lvl_o show the candidate with the highest level, and the lower channel number wins a tie. Both outputs are 0 when there is no candidate.
- R8: irq_req_o is 1 exactly when a candidate exists, cpu_ie_i is 1, and cpu_il_i is strictly less than the winner's level.
- R9: A winner at level 0 never raises irq_req_o.
- R10: sec_trig_o[c] (c = 0, 1) is a one-cycle pulse in the cycle after tc_i[c], produced only when trigger enable c is set, regardless of the interrupt enable.
- R11: The register read data on reg_rdata_o reflects reg_addr_i combinationally and shows state as of the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tc_i | input | 4 | Per-channel terminal-count pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| cpu_ie_i | input | 1 | CPU global interrupt enable |
| cpu_il_i | input | 3 | CPU current interrupt level |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_ch_o | output | 2 | Winning channel number |
| irq_lvl_o | output | 3 | Winning channel level |
| sec_trig_o | output | 2 | Secondary DMA trigger, channels 0 and 1 |

## Verification
The risky overlap is a terminal-count pulse on a channel that lands in the same cycle as a write-one-to-clear of that channel's flag. The flag must survive this. Random stimulus fires terminal counts and flag-clear writes independently every cycle, so the overlap occurs many times. A directed case also forces it on one channel while a neighbour is cleared. After each such edge the flag byte is read back and compared with a bench model in which the set wins, and the arbitration outputs are checked against the model in the same cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  parameter int unsigned FLAG_ADDR = 0;
  parameter int unsigned EN_ADDR   = 1;
  parameter int unsigned LVL_BASE  = 2;
  parameter int unsigned NIB       = 4;
endpackage

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned TRIG_CH = 2,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CH-1:0]             tc_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [7:0]                  wdata_i,
  output logic [7:0]                  rdata_o,
  output logic [N_CH-1:0]             flag_o,
  output logic [N_CH-1:0]             en_o,
  output logic [TRIG_CH-1:0]          ten_o,
  output logic [N_CH-1:0][LVL_W-1:0]  lvl_o
);
  logic wr_flag, wr_en;
  assign wr_flag = we_i && (addr_i == ADDR_W'(FLAG_ADDR));
  assign wr_en   = we_i && (addr_i == ADDR_W'(EN_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= '0;
      en_o   <= '0;
      ten_o  <= '0;
    end else begin
      // set beats clear
      flag_o <= (flag_o & ~(wr_flag ? wdata_i[N_CH-1:0] : '0)) | tc_i;
      if (wr_en) begin
        en_o  <= wdata_i[N_CH-1:0];
        ten_o <= wdata_i[N_CH +: TRIG_CH];
      end
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_lvl
    localparam int unsigned LA = LVL_BASE + i / 2;
    localparam int unsigned LB = (i % 2) * NIB;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_o[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(LA)) lvl_o[i] <= wdata_i[LB +: LVL_W];
    end

    a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_i[i] |=> flag_o[i]);
    a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_flag && wdata_i[i] && !tc_i[i]) |=> !flag_o[i]);
    a_r2_rise_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> $past(tc_i[i]));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(FLAG_ADDR)) rdata_o[N_CH-1:0] = flag_o;
    if (addr_i == ADDR_W'(EN_ADDR)) rdata_o[N_CH+TRIG_CH-1:0] = {ten_o, en_o};
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(LVL_BASE + i / 2))
        rdata_o[(i % 2) * NIB +: LVL_W] = lvl_o[i];
    end
  end
endmodule

// File: rtl/dma_irq_pick.sv
module dma_irq_pick #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]             cand_i,
  input  logic [N_CH-1:0][LVL_W-1:0]  lvl_i,
  output logic                        any_o,
  output logic [CH_W-1:0]             ch_o,
  output logic [LVL_W-1:0]            lvl_o
);
  // strict compare keeps the lower index on a tie
  always_comb begin
    any_o = 1'b0;
    ch_o  = '0;
    lvl_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (cand_i[i] && (!any_o || lvl_i[i] > lvl_o)) begin
        any_o = 1'b1;
        ch_o  = CH_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/dma_irq_arbiter.sv
module dma_irq_arbiter #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned TRIG_CH = 2,
  localparam int unsigned CH_W   = $clog2(N_CH),
  localparam int unsigned ADDR_W = $clog2(2 + (N_CH + 1) / 2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_CH-1:0]     tc_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic                cpu_ie_i,
  input  logic [LVL_W-1:0]    cpu_il_i,
  output logic                irq_req_o,
  output logic [CH_W-1:0]     irq_ch_o,
  output logic [LVL_W-1:0]    irq_lvl_o,
  output logic [TRIG_CH-1:0]  sec_trig_o
);
  logic [N_CH-1:0]            flag, en;
  logic [TRIG_CH-1:0]         ten;
  logic [N_CH-1:0][LVL_W-1:0] lvl;
  logic                       any;

  dma_irq_regs #(
    .N_CH(N_CH), .LVL_W(LVL_W), .TRIG_CH(TRIG_CH), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk_i, .rst_ni, .tc_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .flag_o(flag), .en_o(en), .ten_o(ten), .lvl_o(lvl)
  );

  dma_irq_pick #(.N_CH(N_CH), .LVL_W(LVL_W)) i_pick (
    .cand_i(flag & en), .lvl_i(lvl),
    .any_o(any), .ch_o(irq_ch_o), .lvl_o(irq_lvl_o)
  );

  assign irq_req_o = any && cpu_ie_i && (cpu_il_i < irq_lvl_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_trig_o <= '0;
    else         sec_trig_o <= tc_i[TRIG_CH-1:0] & ten;
  end

  a_r8_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (cpu_ie_i && cpu_il_i < irq_lvl_o));
  a_r9_no_level_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_lvl_o != '0));
  a_r7_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (flag[irq_ch_o] && en[irq_ch_o]));

  for (genvar t = 0; t < TRIG_CH; t++) begin : g_trig_chk
    a_r10_trig_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_trig_o[t] |-> $past(tc_i[t]));
  end
endmodule

// File: tb/test_dma_irq_arbiter.sv
module test_dma_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tc = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ie = 1'b0;
  logic [2:0] il = '0;
  logic       req;
  logic [1:0] ch;
  logic [2:0] lvl;
  logic [1:0] trig;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] m_flag, m_en;
  logic [1:0] m_ten, m_trig;
  logic [2:0] m_lvl [4];

  always #5 clk = ~clk;

  dma_irq_arbiter i_dma_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .tc_i(tc),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_ie_i(ie), .cpu_il_i(il),
    .irq_req_o(req), .irq_ch_o(ch), .irq_lvl_o(lvl), .sec_trig_o(trig)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_flag};
      2'd1: return {2'b0, m_ten, m_en};
      2'd2: return {1'b0, m_lvl[1], 1'b0, m_lvl[0]};
      default: return {1'b0, m_lvl[3], 1'b0, m_lvl[2]};
    endcase
  endfunction

  task automatic m_win(output logic any, output logic [1:0] wc, output logic [2:0] wl);
    any = 0; wc = 0; wl = 0;
    for (int i = 0; i < 4; i++)
      if (m_flag[i] && m_en[i] && (!any || m_lvl[i] > wl)) begin
        any = 1; wc = 2'(i); wl = m_lvl[i];
      end
  endtask

  task automatic m_reset();
    m_flag = '0; m_en = '0; m_ten = '0; m_trig = '0;
    for (int i = 0; i < 4; i++) m_lvl[i] = '0;
  endtask

  // one clock: drive at negedge, check, then advance model across posedge
  task automatic cycle(logic [3:0] t, logic w, logic [1:0] a, logic [7:0] d,
                       logic e, logic [2:0] l);
    logic any; logic [1:0] wc; logic [2:0] wl;
    @(negedge clk);
    tc = t; we = w; addr = a; wdata = d; ie = e; il = l;
    #1;
    m_win(any, wc, wl);
    check("R2 R5 R6 R11 readback", rdata, m_read(a));
    check("R7 winner channel", 8'(ch), 8'(wc));
    check("R7 winner level", 8'(lvl), 8'(wl));
    check("R8 R9 request", 8'(req), 8'(any && e && (l < wl)));
    check("R10 trigger", 8'(trig), 8'(m_trig));
    m_trig = t[1:0] & m_ten;
    m_flag = (m_flag & ~((w && a == 2'd0) ? d[3:0] : 4'b0)) | t;
    if (w && a == 2'd1) begin m_en = d[3:0]; m_ten = d[5:4]; end
    if (w && a == 2'd2) begin m_lvl[0] = d[2:0]; m_lvl[1] = d[6:4]; end
    if (w && a == 2'd3) begin m_lvl[2] = d[2:0]; m_lvl[3] = d[6:4]; end
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = 2'(a); ie = 1; il = 0; #1;
      check("R1 reset register", rdata, 8'h00);
      check("R1 reset request", 8'(req), 8'h00);
    end

    // R2 flag latches while disabled, no request
    cycle(4'b0100, 0, 0, 0, 1, 0);
    cycle(4'b0000, 0, 0, 0, 1, 0);
    check("R2 flag set while disabled", rdata, 8'h04);
    check("R2 no request while disabled", 8'(req), 8'h00);

    // R7 tie: all at level 5, all pending -> channel 0
    cycle(4'b0000, 1, 2, 8'h55, 1, 0);
    cycle(4'b0000, 1, 3, 8'h55, 1, 0);
    cycle(4'b0000, 1, 1, 8'h3f, 1, 0);
    cycle(4'b1111, 0, 0, 0, 1, 0);
    cycle(4'b0000, 0, 1, 0, 1, 4);
    check("R7 tie goes to channel 0", 8'(ch), 8'h00);
    check("R8 request level 5 over 4", 8'(req), 8'h01);
    check("R10 trigger both after pulse", 8'(trig), 8'h03);
    cycle(4'b0000, 0, 0, 0, 1, 5);
    check("R8 equal level blocked", 8'(req), 8'h00);

    // R4 clear all while ch2 completes again
    cycle(4'b0100, 1, 0, 8'h0f, 1, 0);
    cycle(4'b0000, 0, 0, 0, 1, 0);
    check("R4 set beats clear", rdata, 8'h04);
    // R3 partial clear leaves others
    cycle(4'b0011, 0, 0, 0, 1, 0);
    cycle(4'b0000, 1, 0, 8'h01, 1, 0);
    cycle(4'b0000, 0, 0, 0, 1, 0);
    check("R3 clear only written bit", rdata, 8'h06);

    // R9 level zero winner never requests
    cycle(4'b0000, 1, 2, 8'h00, 1, 0);
    cycle(4'b0000, 1, 3, 8'h00, 1, 0);
    cycle(4'b0000, 0, 0, 0, 1, 0);
    check("R9 level zero silent", 8'(req), 8'h00);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] t;
      t = 4'($urandom) & 4'($urandom) & 4'($urandom);
      cycle(t, 1'($urandom), 2'($urandom), 8'($urandom),
            ($urandom % 4) != 0, 3'($urandom));
    end

    // reset mid-run returns to R1 state
    @(negedge clk); rst_n = 1'b0; #1; rst_n = 1'b1;
    m_reset();
    addr = 2'd1; #1;
    check("R1 reset clears enables", rdata, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule